// File: doc/BRIEF.md
# Four-Lane Masked Group Reduce and Scan Unit

This unit combines the words of four parallel lanes under one selected operation. It serves a small SIMD datapath that needs group-wide results across its lanes. Each request carries four 32-bit lane words, a 4-bit mask of live lanes, an operation code and a group mode. The modes are a reduction, an inclusive prefix scan and an exclusive prefix scan. Lanes whose mask bit is clear take no part in the result: before any combining, the unit replaces their words with the neutral element of the chosen operation.

The combining network is fixed and has two levels. A reduction pairs lanes 0 with 1 and lanes 2 with 3, then merges the two partial results, and broadcasts the final value to every lane. A scan first merges each lane with its neighbour one position below, then merges that result with the step-one value two positions below. An exclusive scan moves the inclusive result up by one lane and puts the neutral element in lane 0. A single register stage holds the result, and the output qualifier follows the input qualifier one clock later.

Top module: `lane_scan_unit`

## Requirements
- R1: A lane whose mask bit is 0 contributes the neutral value of the operation. That value is 0 for ADD, OR, XOR, UMAX, LOR and LXOR; 1 for MUL; all-ones for AND, UMIN and LAND; 0x7FFFFFFF for SMIN; 0x80000000 for SMAX.
- R2: In reduce mode (in_mode = 0), all four output lanes carry the same value, which is the combination of all four (substituted) lane words.
- R3: In inclusive-scan mode (in_mode = 1), output lane k carries the combination of lanes 0 through k.
- R4: In exclusive-scan mode (in_mode = 2), output lane 0 carries the neutral value and output lane k (k ≥ 1) carries the combination of lanes 0 through k-1.
- R5: ADD (in_op = 0) and MUL (in_op = 1) wrap modulo 2^32, and MUL keeps only the low 32 bits of each product.
- R6: The op codes are SMIN = 5, SMAX = 6, UMIN = 7 and UMAX = 8. The SMIN and SMAX codes compare as two's-complement, and the UMIN and UMAX codes compare as unsigned. The bitwise ops are AND = 2, OR = 3 and XOR = 4.
- R7: The logical ops are LAND = 9, LOR = 10 and LXOR = 11. They treat any nonzero word as true, and every lane result they produce is either all-ones (true) or zero (false).
- R8: Op codes 12 to 15, and mode code 3, produce an all-zero result vector with out_err = 1. A legal request gives out_err = 0.
- R9: The result and out_valid = 1 appear on the clock edge after the one that samples in_valid = 1. When in_valid = 0, out_valid goes to 0 on the next edge and out_lanes keeps its value.
- R10: While rst_n is low at a clock edge, out_valid, out_err and out_lanes are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| in_lanes | input | 128 | Lane words, lane k in bits [32k+31:32k] |
| in_mask | input | 4 | Live-lane mask, bit k for lane k |
| in_op | input | 4 | Operation code |
| in_mode | input | 2 | 0 reduce, 1 inclusive scan, 2 exclusive scan |
| out_valid | output | 1 | Result qualifier |
| out_lanes | output | 128 | Result words, same lane layout |
| out_err | output | 1 | Unused op or mode code in the request |

## Verification
The sweep covers every op code, every mode code and all sixteen masks, using lane data that holds the signed extremes, zero, all-ones and pseudo-random words. A wrong neutral value shows up as soon as a lane is masked off, most clearly for SMIN and SMAX, which need the extreme words. A swapped signed or unsigned compare fails on the mix of 0x80000000 and 0x7FFFFFFF. Shifting the scan by the wrong distance breaks lanes 2 and 3. Inserting the wrong value in exclusive lane 0 breaks that lane alone. A logical op that passes the raw word through gives non-normalized lanes. Idle cycles placed between requests catch a result register that reloads without a request.

// File: rtl/lane_scan_pkg.sv
// Shared definitions for the four-lane group reduce/scan unit.
// Assumes a fixed group of four lanes; the word width is a module parameter.
package lane_scan_pkg;

    localparam int LANES = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_MUL  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SMIN = 4'd5,
        OP_SMAX = 4'd6,
        OP_UMIN = 4'd7,
        OP_UMAX = 4'd8,
        OP_LAND = 4'd9,
        OP_LOR  = 4'd10,
        OP_LXOR = 4'd11
    } lane_op_e;

    typedef enum logic [1:0] {
        MODE_REDUCE = 2'd0,
        MODE_INCL   = 2'd1,
        MODE_EXCL   = 2'd2
    } group_mode_e;

endpackage

// File: rtl/lsu_identity.sv
// Neutral-element generator: gives the value that leaves any word unchanged
// under the selected operation, and flags op codes that are not defined.
// Assumes op codes above OP_LXOR are unused.
module lsu_identity
    import lane_scan_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] ident,
    output logic             op_ok
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] SGN_MAX  = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] SGN_MIN  = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    // Purpose: map the op code to its neutral value and legality.
    always_comb begin
        op_ok = 1'b1;
        case (lane_op_e'(op))
            OP_MUL:                    ident = ONE;
            OP_AND, OP_UMIN, OP_LAND:  ident = ALL_ONES;
            OP_SMIN:                   ident = SGN_MAX;
            OP_SMAX:                   ident = SGN_MIN;
            OP_ADD, OP_OR, OP_XOR, OP_UMAX, OP_LOR, OP_LXOR:
                                       ident = '0;
            default: begin
                ident = '0;
                op_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lsu_combine.sv
// Two-operand combining cell for one operation. Pure combinational logic.
// Assumes the caller has checked legality; unused codes give zero.
module lsu_combine
    import lane_scan_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    logic a_true;
    logic b_true;
    logic s_less;
    logic u_less;

    // Purpose: truth values and comparisons shared by several ops.
    always_comb begin
        a_true = |a;
        b_true = |b;
        s_less = $signed(a) < $signed(b);
        u_less = a < b;
    end

    // Purpose: select the result of the requested operation.
    always_comb begin
        case (lane_op_e'(op))
            OP_ADD:  y = a + b;
            OP_MUL:  y = a * b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SMIN: y = s_less ? a : b;
            OP_SMAX: y = s_less ? b : a;
            OP_UMIN: y = u_less ? a : b;
            OP_UMAX: y = u_less ? b : a;
            OP_LAND: y = {WIDTH{a_true & b_true}};
            OP_LOR:  y = {WIDTH{a_true | b_true}};
            OP_LXOR: y = {WIDTH{a_true ^ b_true}};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/lsu_scan_net.sv
// Masked combining network across four lanes. It substitutes the neutral
// value for dead lanes, then builds the reduction tree and the two-step
// prefix network, and gives out the reduce, inclusive and exclusive results.
// Assumes exactly four lanes; the operation must be commutative.
module lsu_scan_net
    import lane_scan_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]             op,
    input  logic [WIDTH-1:0]       ident,
    input  logic [LANES*WIDTH-1:0] lanes,
    input  logic [LANES-1:0]       mask,
    output logic [WIDTH-1:0]       red_word,
    output logic [LANES*WIDTH-1:0] incl_lanes,
    output logic [LANES*WIDTH-1:0] excl_lanes
);

    logic [WIDTH-1:0] live  [LANES];
    logic [WIDTH-1:0] step1 [LANES];
    logic [WIDTH-1:0] step2 [LANES];
    logic [WIDTH-1:0] pair_lo;
    logic [WIDTH-1:0] pair_hi;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            logic [WIDTH-1:0] nb1;
            logic [WIDTH-1:0] nb2;

            // Purpose: substitute the neutral value in dead lanes.
            always_comb live[k] = mask[k] ? lanes[k*WIDTH +: WIDTH] : ident;

            if (k >= 1) begin : g_nb1
                always_comb nb1 = live[k-1];
            end else begin : g_nb1_edge
                always_comb nb1 = ident;
            end

            if (k >= 2) begin : g_nb2
                always_comb nb2 = step1[k-2];
            end else begin : g_nb2_edge
                always_comb nb2 = ident;
            end

            lsu_combine #(.WIDTH(WIDTH)) u_s1 (
                .op(op), .a(live[k]), .b(nb1), .y(step1[k]));
            lsu_combine #(.WIDTH(WIDTH)) u_s2 (
                .op(op), .a(step1[k]), .b(nb2), .y(step2[k]));

            // Purpose: pack the inclusive result.
            always_comb incl_lanes[k*WIDTH +: WIDTH] = step2[k];

            if (k == 0) begin : g_ex0
                always_comb excl_lanes[k*WIDTH +: WIDTH] = ident;
            end else begin : g_exk
                always_comb excl_lanes[k*WIDTH +: WIDTH] = step2[k-1];
            end
        end
    endgenerate

    lsu_combine #(.WIDTH(WIDTH)) u_pair_lo (
        .op(op), .a(live[0]), .b(live[1]), .y(pair_lo));
    lsu_combine #(.WIDTH(WIDTH)) u_pair_hi (
        .op(op), .a(live[2]), .b(live[3]), .y(pair_hi));
    lsu_combine #(.WIDTH(WIDTH)) u_root (
        .op(op), .a(pair_lo), .b(pair_hi), .y(red_word));

endmodule

// File: rtl/lane_scan_unit.sv
// Four-lane masked reduce/scan unit, top level. It checks the op and mode
// codes, picks the network output for the mode and registers it for one
// cycle. Reset is synchronous and active low. Assumes four lanes.
module lane_scan_unit
    import lane_scan_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [4*WIDTH-1:0]     in_lanes,
    input  logic [3:0]             in_mask,
    input  logic [3:0]             in_op,
    input  logic [1:0]             in_mode,
    output logic                   out_valid,
    output logic [4*WIDTH-1:0]     out_lanes,
    output logic                   out_err
);

    localparam int VEC_W = LANES * WIDTH;

    logic [WIDTH-1:0] ident;
    logic             op_ok;
    logic             mode_ok;
    logic [WIDTH-1:0] red_word;
    logic [VEC_W-1:0] incl_lanes;
    logic [VEC_W-1:0] excl_lanes;
    logic [VEC_W-1:0] next_lanes;

    lsu_identity #(.WIDTH(WIDTH)) u_ident (
        .op(in_op), .ident(ident), .op_ok(op_ok));

    lsu_scan_net #(.WIDTH(WIDTH)) u_net (
        .op(in_op), .ident(ident), .lanes(in_lanes), .mask(in_mask),
        .red_word(red_word), .incl_lanes(incl_lanes), .excl_lanes(excl_lanes));

    // Purpose: choose the mode result, or zero for an unused code.
    always_comb begin
        mode_ok = 1'b1;
        case (group_mode_e'(in_mode))
            MODE_REDUCE: next_lanes = {LANES{red_word}};
            MODE_INCL:   next_lanes = incl_lanes;
            MODE_EXCL:   next_lanes = excl_lanes;
            default: begin
                next_lanes = '0;
                mode_ok    = 1'b0;
            end
        endcase
        if (!op_ok) next_lanes = '0;
    end

    // Purpose: output register stage, loaded only on a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_lanes <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_err   <= !(op_ok && mode_ok);
                out_lanes <= next_lanes;
            end
        end
    end

endmodule

// File: rtl/lane_scan_unit_chk.sv
// Property checker for lane_scan_unit, attached by bind below.
module lane_scan_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [3:0]         in_mask,
    input logic [3:0]         in_op,
    input logic [1:0]         in_mode,
    input logic               out_valid,
    input logic [4*WIDTH-1:0] out_lanes,
    input logic               out_err
);

    logic [WIDTH-1:0] l0, l1, l2, l3;
    assign l0 = out_lanes[0*WIDTH +: WIDTH];
    assign l1 = out_lanes[1*WIDTH +: WIDTH];
    assign l2 = out_lanes[2*WIDTH +: WIDTH];
    assign l3 = out_lanes[3*WIDTH +: WIDTH];

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_lanes)));

    a_r8_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd12) |=> (out_err && out_lanes == '0));

    a_r8_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd3) |=> (out_err && out_lanes == '0));

    a_r2_reduce_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd0 && in_op < 4'd12)
        |=> (!out_err && l0 == l1 && l1 == l2 && l2 == l3));

    a_r4_excl_lane0_and: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd2 && in_op == 4'd2) |=> (l0 == '1));

    a_r1_incl_dead_add: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd1 && in_op == 4'd0 && !in_mask[0])
        |=> (l0 == '0));

    a_r7_logic_norm: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd9 && in_op <= 4'd11 && in_mode != 2'd3)
        |=> ((l0 == '0 || l0 == '1) && (l1 == '0 || l1 == '1) &&
             (l2 == '0 || l2 == '1) && (l3 == '0 || l3 == '1)));

endmodule

bind lane_scan_unit lane_scan_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
    .in_op(in_op), .in_mode(in_mode), .out_valid(out_valid),
    .out_lanes(out_lanes), .out_err(out_err));

// File: tb/lane_scan_unit_test.sv
module lane_scan_unit_test;

    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic [4*W-1:0] in_lanes;
    logic [3:0]     in_mask;
    logic [3:0]     in_op;
    logic [1:0]     in_mode;
    logic           out_valid;
    logic [4*W-1:0] out_lanes;
    logic           out_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    lane_scan_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
        .in_mask(in_mask), .in_op(in_op), .in_mode(in_mode),
        .out_valid(out_valid), .out_lanes(out_lanes), .out_err(out_err));

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // Neutral values from R1.
    function automatic logic [31:0] b_ident(input logic [3:0] op);
        case (op)
            4'd1:             return 32'd1;
            4'd2, 4'd7, 4'd9: return 32'hFFFF_FFFF;
            4'd5:             return 32'h7FFF_FFFF;
            4'd6:             return 32'h8000_0000;
            default:          return 32'd0;
        endcase
    endfunction

    // Operation semantics from R5, R6 and R7.
    function automatic logic [31:0] b_comb(input logic [3:0] op,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
        longint sa, sb;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            4'd0: return a + b;
            4'd1: begin p = {32'd0, a} * {32'd0, b}; return p[31:0]; end
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return (sa <= sb) ? a : b;
            4'd6: return (sa >= sb) ? a : b;
            4'd7: return (a <= b) ? a : b;
            4'd8: return (a >= b) ? a : b;
            4'd9:  return ((a != 0) && (b != 0)) ? 32'hFFFF_FFFF : 32'd0;
            4'd10: return ((a != 0) || (b != 0)) ? 32'hFFFF_FFFF : 32'd0;
            4'd11: return ((a != 0) != (b != 0)) ? 32'hFFFF_FFFF : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic [1:0] mode,
                                     input logic [3:0] mask);
        string s;
        if (op >= 4'd12 || mode == 2'd3) return "R8";
        s = (mode == 2'd0) ? "R2" : (mode == 2'd1) ? "R3" : "R4";
        if (op <= 4'd1) s = {s, "/R5"};
        else if (op >= 4'd5 && op <= 4'd8) s = {s, "/R6"};
        else if (op >= 4'd9) s = {s, "/R7"};
        if (mask != 4'hF) s = {s, "/R1"};
        return {s, "/R9"};
    endfunction

    // Serial accumulation model of the requirements.
    task automatic expect_vec(input logic [4*W-1:0] d, input logic [3:0] m,
                              input logic [3:0] op, input logic [1:0] mode,
                              output logic [4*W-1:0] e, output logic err);
        logic [31:0] id, acc;
        logic [31:0] inc [4];
        id  = b_ident(op);
        acc = id;
        for (int j = 0; j < 4; j++) begin
            acc    = b_comb(op, acc, m[j] ? d[j*32 +: 32] : id);
            inc[j] = acc;
        end
        err = (op >= 4'd12) || (mode == 2'd3);
        e   = '0;
        if (!err) begin
            for (int j = 0; j < 4; j++) begin
                case (mode)
                    2'd0:    e[j*32 +: 32] = inc[3];
                    2'd1:    e[j*32 +: 32] = inc[j];
                    default: e[j*32 +: 32] = (j == 0) ? id : inc[j-1];
                endcase
            end
        end
    endtask

    task automatic apply_one(input logic [4*W-1:0] d, input logic [3:0] m,
                             input logic [3:0] op, input logic [1:0] mode);
        logic [4*W-1:0] e;
        logic err;
        expect_vec(d, m, op, mode, e, err);
        in_valid = 1'b1; in_lanes = d; in_mask = m; in_op = op; in_mode = mode;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || out_lanes !== e || out_err !== err) begin
            fails++;
            $display("FAIL %s op=%0d mode=%0d mask=%h: got v=%b err=%b %h, expected v=1 err=%b %h",
                     tag_of(op, mode, m), op, mode, m, out_valid, out_err, out_lanes, err, e);
        end
    endtask

    task automatic idle_one();
        logic [4*W-1:0] prev;
        prev = out_lanes;
        in_valid = 1'b0;
        seed = nxt(seed);
        in_lanes = {4{seed}};
        in_op = seed[3:0];
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_lanes !== prev) begin
            fails++;
            $display("FAIL R9 idle: got v=%b %h, expected v=0 %h", out_valid, out_lanes, prev);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [4*W-1:0] d;
        int n;
        rst_n = 1'b0; in_valid = 1'b0; in_lanes = '0;
        in_mask = '0; in_op = '0; in_mode = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_lanes !== '0) begin
            fails++;
            $display("FAIL R10 reset: got v=%b err=%b %h, expected 0 0 0",
                     out_valid, out_err, out_lanes);
        end
        rst_n = 1'b1;
        n = 0;
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: d = {32'hFFFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000};
                1: d = {32'h0001_0001, 32'h0000_0005, 32'hFFFF_FFFE, 32'h0000_0003};
                default: begin
                    for (int j = 0; j < 4; j++) begin
                        seed = nxt(seed);
                        d[j*32 +: 32] = (p == 2 && j == 1) ? 32'd0 : seed;
                    end
                end
            endcase
            for (int op = 0; op < 16; op++)
                for (int mode = 0; mode < 4; mode++)
                    for (int m = 0; m < 16; m++) begin
                        apply_one(d, 4'(m), 4'(op), 2'(mode));
                        n++;
                        if (n % 16 == 0) idle_one();
                    end
        end
        idle_one();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule